// File: doc/BRIEF.md
# Transition-Reducing Pseudorandom Pattern Source

This block is a four-stage shift register with linear feedback that walks through every nonzero 4-bit value, with period 15. It is meant for driving test stimulus into downstream logic. Next to the raw state it gives a second word, the low-activity word. This word is built by a row of 2:1 multiplexers, and all of them share one select: the lowest stage of the register. When that stage holds 1, the two lowest bits are exchanged on the way out. The result is fewer bit flips between consecutive words than the raw state shows.

The register steps only while the enable is high and holds its value otherwise. A synchronous reset places it at 0001, which is a safe value outside the all-zero lock-up. The exchange acts only on the output path. The feedback always uses the unswapped stored value.

Top module: `lowtrans_lfsr`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads state 0001. The low-activity word is then 0010.
- R2: With `en` low and `rst` low, the state keeps its value across a clock edge.
- R3: With `en` high and `rst` low, each edge shifts the state one place toward bit 0. The new bit 3 is old bit 0 XOR old bit 1, which is polynomial 1 + x^3 + x^4.
- R4: From 0001 the state visits 1000, 0100, 0010, 1001, 1100, 0110, 1011, 0101, 1010, 1101, 1110, 1111, 0111, 0011 in that order, then returns to 0001 after 15 steps. It never holds 0000.
- R5: When state bit 0 is 0, the low-activity word equals the state.
- R6: When state bit 0 is 1, the low-activity word has bit 1 = state bit 0 and bit 0 = state bit 1. Bits 3 and 2 pass straight through.
- R7: The exchange never changes the stored state. The next state is always computed from the unswapped value.
- R8: Over one full period (15 cyclic steps), the summed Hamming distance between consecutive low-activity words is 24. The same sum for the state is 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable |
| state_o | output | 4 | Raw register state |
| lp_word_o | output | 4 | Low-activity output word |

## Verification
On every cycle, the assertions check the reset value, holding while disabled, the shift-and-feedback step taken from the unswapped state, that the state is never zero, and both the pass-through and exchange rules of the output word. Only the bench scenarios can show the things that span a whole run. These are: the exact 15-value order, the return to 0001 after a full period, that 15 distinct values are visited, and the total Hamming distance of 24 against 32 over one period.

// File: rtl/lowtrans_pkg.sv
package lowtrans_pkg;
    parameter int unsigned LFSR_W = 4;
    typedef logic [LFSR_W-1:0] word_t;

    typedef struct packed {
        word_t state;
    } core_s;

    // partner index for a bit in the exchange network
    function automatic int unsigned partner_idx(input int unsigned i, input int unsigned lo);
        if (i == lo)       return lo + 1;
        if (i == lo + 1)   return lo;
        return i;
    endfunction
endpackage

// File: rtl/lowtrans_mux2.sv
module lowtrans_mux2 (
    input  logic a_i,
    input  logic b_i,
    input  logic sel_i,
    output logic y_o
);
    always_comb begin
        y_o = sel_i ? b_i : a_i;
    end
endmodule

// File: rtl/lowtrans_core.sv
module lowtrans_core
    import lowtrans_pkg::*;
#(
    parameter word_t       SEED  = word_t'(1),
    parameter int unsigned TAP_A = 0,
    parameter int unsigned TAP_B = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    output word_t state_o
);
    localparam int unsigned MSB = LFSR_W - 1;

    core_s core_d, core_q;

    always_comb begin
        core_d = core_q;
        if (rst) begin
            core_d.state = SEED;
        end else if (en) begin
            core_d.state = {core_q.state[TAP_A] ^ core_q.state[TAP_B], core_q.state[MSB:1]};
        end
    end

    always_ff @(posedge clk) begin
        core_q <= core_d;
    end

    assign state_o = core_q.state;
endmodule

// File: rtl/lowtrans_swap_net.sv
module lowtrans_swap_net
    import lowtrans_pkg::*;
#(
    parameter int unsigned SEL_IDX = 0,
    parameter int unsigned PAIR_LO = 0
) (
    input  word_t state_i,
    output word_t word_o
);
    for (genvar i = 0; i < LFSR_W; i++) begin : g_bit
        localparam int unsigned ALT = partner_idx(i, PAIR_LO);
        lowtrans_mux2 u_mux (
            .a_i   (state_i[i]),
            .b_i   (state_i[ALT]),
            .sel_i (state_i[SEL_IDX]),
            .y_o   (word_o[i])
        );
    end
endmodule

// File: rtl/lowtrans_lfsr.sv
module lowtrans_lfsr
    import lowtrans_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    output logic [3:0] state_o,
    output logic [3:0] lp_word_o
);
    localparam int unsigned LAST_STAGE = 0;
    localparam int unsigned SWAP_LO    = 0;

    word_t state_w;
    word_t word_w;

    lowtrans_core #(
        .SEED  (word_t'(1)),
        .TAP_A (0),
        .TAP_B (1)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .state_o (state_w)
    );

    lowtrans_swap_net #(
        .SEL_IDX (LAST_STAGE),
        .PAIR_LO (SWAP_LO)
    ) u_swap (
        .state_i (state_w),
        .word_o  (word_w)
    );

    assign state_o   = state_w;
    assign lp_word_o = word_w;
endmodule

// File: rtl/lowtrans_lfsr_chk.sv
module lowtrans_lfsr_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic [3:0] state_o,
    input logic [3:0] lp_word_o
);
    p_reset_seed_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> state_o == 4'b0001);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(en)) |-> $stable(state_o));

    // R7: step uses the stored, unswapped value
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en)) |->
            state_o == {$past(state_o[0]) ^ $past(state_o[1]), $past(state_o[3:1])});

    p_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        state_o != 4'b0000);

    p_pass_r5: assert property (@(posedge clk) disable iff (rst)
        !state_o[0] |-> lp_word_o == state_o);

    p_swap_r6: assert property (@(posedge clk) disable iff (rst)
        state_o[0] |-> (lp_word_o[3:2] == state_o[3:2] && lp_word_o[1] && lp_word_o[0] == state_o[1]));
endmodule

bind lowtrans_lfsr lowtrans_lfsr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .state_o   (state_o),
    .lp_word_o (lp_word_o)
);

// File: tb/lowtrans_lfsr_tb_top.sv
module lowtrans_lfsr_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [3:0] state_o;
    logic [3:0] lp_word_o;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lowtrans_lfsr dut_i (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .state_o   (state_o),
        .lp_word_o (lp_word_o)
    );

    function automatic logic [3:0] m_next(input logic [3:0] s);
        return {s[0] ^ s[1], s[3:1]};
    endfunction

    function automatic logic [3:0] m_word(input logic [3:0] s);
        return s[0] ? {s[3:2], s[0], s[1]} : s;
    endfunction

    function automatic int hd(input logic [3:0] a, input logic [3:0] b);
        return $countones(a ^ b);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; en = 1'b1;
        @(negedge clk);
        chk("R1 state", 32'(state_o), 32'h1);
        chk("R1 word", 32'(lp_word_o), 32'h2);
        rst = 1'b0;
    endtask

    task automatic t_hold;
        logic [3:0] s0;
        en = 1'b1;
        @(negedge clk); @(negedge clk);
        s0 = state_o;
        en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 hold", 32'(state_o), 32'(s0));
        chk("R5/R6 word while held", 32'(lp_word_o), 32'(m_word(s0)));
    endtask

    task automatic t_period;
        logic [3:0] s, exp_seq [15];
        logic [15:0] seen;
        int hs, hw, nseen;
        exp_seq = '{4'h1, 4'h8, 4'h4, 4'h2, 4'h9, 4'hC, 4'h6, 4'hB,
                    4'h5, 4'hA, 4'hD, 4'hE, 4'hF, 4'h7, 4'h3};
        rst = 1'b1; en = 1'b0;
        @(negedge clk);
        rst = 1'b0; en = 1'b1;
        hs = 0; hw = 0; seen = '0;
        for (int k = 0; k < 15; k++) begin
            s = state_o;
            chk("R4 order", 32'(s), 32'(exp_seq[k]));
            chk("R4 nonzero", 32'(s != 4'h0), 32'h1);
            if (s[0]) chk("R6 swap", 32'(lp_word_o), 32'(m_word(s)));
            else      chk("R5 pass", 32'(lp_word_o), 32'(s));
            seen[s] = 1'b1;
            @(negedge clk);
            chk("R3 R7 step", 32'(state_o), 32'(m_next(s)));
            hs += hd(s, state_o);
            hw += hd(m_word(s), lp_word_o);
        end
        nseen = $countones(seen);
        chk("R4 distinct", 32'(nseen), 32'd15);
        chk("R4 wrap", 32'(state_o), 32'h1);
        chk("R8 state hd", 32'(hs), 32'd32);
        chk("R8 word hd", 32'(hw), 32'd24);
        chk("R8 lower", 32'(hw < hs), 32'h1);
    endtask

    task automatic t_reset_midrun;
        en = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 midrun state", 32'(state_o), 32'h1);
        chk("R1 midrun word", 32'(lp_word_o), 32'h2);
        rst = 1'b0;
        @(negedge clk);
        chk("R3 after reset", 32'(state_o), 32'h8);
    endtask

    initial begin
        t_reset();
        t_hold();
        t_period();
        t_reset_midrun();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule